// File: doc/BRIEF.md
# Direct-Sample Channel Override for Channel Six

This block gives the sound generator a way to play raw 8-bit PCM through its sixth channel. It monitors the decoded register write stream (group select, register address and data) and keeps three small pieces of state: the latest sample byte, an enable flag and the sixth channel's left/right pan gates. Once per output sample period, it publishes a signed 14-bit value for channel six, together with one gated copy for the left side and one for the right.

When the override is enabled, the FM synthesis result for channel six is discarded. The stored byte is centred on zero and scaled up to the FM channel range. When the override is off, the FM result passes through untouched. In both cases the channel's pan gates still apply. No buffering is present, so each sample write replaces the previous one at once. Software must pace its writes to the playback rate it wants.

A free-running counter splits every 24-cycle sample period into six 4-cycle channel slots. The block outputs the current slot index and a one-cycle pulse that marks each new sample.

Top module: `dac6_ch6_sub`

## Requirements
- R1: After reset, the sample byte is 0x80, the override is off and both pan gates are open. Before the first sample pulse, `smp_valid` is 0 and both outputs are 0.
- R2: A group-1 write to address 0x2A stores the data byte as the sample. If several such writes land in one sample period, only the last one before the period ends is used.
- R3: A group-1 write to address 0x2B sets the override flag from data bit 7. Bits 6..0 of that data have no effect.
- R4: While the override is on, the channel value is (sample - 128) * 64 in 14-bit two's complement. For example, 0xFF gives 0x1FC0, 0x00 gives 0x2000 and 0x81 gives 0x0040. `fm_ch6` is ignored in this mode.
- R5: While the override is off, the channel value equals `fm_ch6` as sampled at the end of the period.
- R6: A group-2 write to address 0xB6 sets the left gate from bit 7 and the right gate from bit 6. A closed side outputs 0. This applies in both modes.
- R7: Writes that hit the right address in the wrong group change nothing. This covers 0x2A or 0x2B written in group 2, and 0xB6 written in group 1.
- R8: `smp_valid` pulses for exactly one cycle every 24 cycles. `slot_idx` reads 0 in the pulse cycle and steps by one every 4 cycles, reaching 5 in the last slot.
- R9: `ch6_left` and `ch6_right` hold their value between pulses, even while the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Decoded register write strobe |
| wr_grp | input | 1 | Register group of the write: 0 = first, 1 = second |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register data |
| fm_ch6 | input | 14 | Signed FM result for channel six |
| smp_valid | output | 1 | One-cycle pulse when new outputs are published |
| slot_idx | output | 3 | Current channel slot within the sample period |
| ch6_left | output | 14 | Channel-six value after the left gate |
| ch6_right | output | 14 | Channel-six value after the right gate |

## Verification
The conversion is exercised with the sample bytes at its extremes and at its midpoint: 0x00, 0x80, 0x81 and 0xFF. These show whether the bias is applied and whether the sign and the shift land in the right bits. FM pass-through is tested with its most positive and most negative codes, which would expose any conversion wrongly applied in that mode. All four pan combinations are driven in both modes, so that swapped or inverted gates are caught. Enable data with bit 7 clear but the low bits set is also sent. Writes to the correct address in the wrong group, and back-to-back sample writes within one period, separate correct address decoding from loose decoding and show that only the newest sample takes effect.

// File: rtl/dac6_pkg.sv
package dac6_pkg;
  localparam int SMP_W        = 8;
  localparam int OUT_W        = 14;
  localparam int SHIFT        = OUT_W - SMP_W;
  localparam int CYC_PER_SLOT = 4;
  localparam int NUM_SLOTS    = 6;
  localparam int CYC_PER_SMP  = CYC_PER_SLOT * NUM_SLOTS;
  localparam int SLOT_W       = $clog2(NUM_SLOTS);
  localparam int CNT_W        = $clog2(CYC_PER_SMP);
  localparam int SUB_W        = (CYC_PER_SLOT > 1) ? $clog2(CYC_PER_SLOT) : 1;

  localparam logic [7:0] A_SAMPLE = 8'h2A;
  localparam logic [7:0] A_ENABLE = 8'h2B;
  localparam logic [7:0] A_PAN    = 8'hB6;
  localparam int EN_BIT    = 7;
  localparam int PAN_L_BIT = 7;
  localparam int PAN_R_BIT = 6;

  typedef struct packed {
    logic [SMP_W-1:0] sample;
    logic             en;
    logic             pan_l;
    logic             pan_r;
  } dac6_regs_t;

  localparam dac6_regs_t REGS_RST = '{sample: 8'h80, en: 1'b0, pan_l: 1'b1, pan_r: 1'b1};

  // Flip the top bit to remove the bias, then shift up into FM scale.
  function automatic logic [OUT_W-1:0] to_fm_scale(input logic [SMP_W-1:0] s);
    return {~s[SMP_W-1], s[SMP_W-2:0], {SHIFT{1'b0}}};
  endfunction
endpackage

// File: rtl/dac6_regfile.sv
module dac6_regfile
  import dac6_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_grp,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  output dac6_regs_t regs_q
);
  dac6_regs_t regs_d;
  logic hit_smp, hit_en, hit_pan;

  always_comb begin
    hit_smp = wr_en && !wr_grp && (wr_addr == A_SAMPLE);
    hit_en  = wr_en && !wr_grp && (wr_addr == A_ENABLE);
    hit_pan = wr_en &&  wr_grp && (wr_addr == A_PAN);
    regs_d  = regs_q;
    if (hit_smp) regs_d.sample = wr_data;
    if (hit_en)  regs_d.en     = wr_data[EN_BIT];
    if (hit_pan) begin
      regs_d.pan_l = wr_data[PAN_L_BIT];
      regs_d.pan_r = wr_data[PAN_R_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     regs_q <= REGS_RST;
    else if (wr_en) regs_q <= regs_d;
  end

  // R2: without a write strobe the stored state stays put
  assert_keep_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q));
  // R7: group-1 writes never reach the pan gates
  assert_pan_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_grp) |=> ($stable(regs_q.pan_l) && $stable(regs_q.pan_r)));
endmodule

// File: rtl/dac6_tick.sv
module dac6_tick
  import dac6_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic              tick,
  output logic [SLOT_W-1:0] slot_q
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [SLOT_W-1:0] slot_d;
  logic              sub_wrap;

  always_comb begin
    tick     = (cnt_q == CNT_W'(CYC_PER_SMP - 1));
    cnt_d    = tick ? '0 : cnt_q + 1'b1;
    sub_wrap = (sub_q == SUB_W'(CYC_PER_SLOT - 1));
    sub_d    = sub_wrap ? '0 : sub_q + 1'b1;
    slot_d   = slot_q;
    if (sub_wrap) slot_d = (slot_q == SLOT_W'(NUM_SLOTS - 1)) ? '0 : slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sub_q  <= '0;
      slot_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      sub_q  <= sub_d;
      slot_q <= slot_d;
    end
  end

  // R8: period counter stays in range
  assert_cnt_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(CYC_PER_SMP));
  // R8: slot counter agrees with the period end
  assert_slot_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (slot_q == SLOT_W'(NUM_SLOTS - 1)));
  assert_slot_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q < SLOT_W'(NUM_SLOTS));
endmodule

// File: rtl/dac6_out.sv
module dac6_out
  import dac6_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  dac6_regs_t       regs,
  input  logic [OUT_W-1:0] fm_in,
  output logic             valid_q,
  output logic [OUT_W-1:0] left_q,
  output logic [OUT_W-1:0] right_q
);
  logic [OUT_W-1:0] val, left_d, right_d;

  always_comb begin
    val     = regs.en ? to_fm_scale(regs.sample) : fm_in;
    left_d  = regs.pan_l ? val : '0;
    right_d = regs.pan_r ? val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
    end else begin
      valid_q <= tick;
      if (tick) begin
        left_q  <= left_d;
        right_q <= right_d;
      end
    end
  end

  // R6: a closed gate yields zero on that side
  assert_gate_left_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !$past(regs.pan_l)) |-> (left_q == '0));
  assert_gate_right_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !$past(regs.pan_r)) |-> (right_q == '0));
  // R4: sample mode output has the low shift bits clear
  assert_dac_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && $past(regs.en) && $past(regs.pan_l)) |-> (left_q[SHIFT-1:0] == '0));
  // R9: outputs only move in the pulse cycle
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> ($stable(left_q) && $stable(right_q)));
  // R8: the pulse is a single cycle
  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
endmodule

// File: rtl/dac6_ch6_sub.sv
module dac6_ch6_sub
  import dac6_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_grp,
  input  logic [7:0]          wr_addr,
  input  logic [7:0]          wr_data,
  input  logic [OUT_W-1:0]    fm_ch6,
  output logic                smp_valid,
  output logic [SLOT_W-1:0]   slot_idx,
  output logic [OUT_W-1:0]    ch6_left,
  output logic [OUT_W-1:0]    ch6_right
);
  dac6_regs_t regs;
  logic       tick;

  dac6_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(wr_grp),
    .wr_addr(wr_addr), .wr_data(wr_data), .regs_q(regs)
  );

  dac6_tick u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick), .slot_q(slot_idx)
  );

  dac6_out u_out (
    .clk(clk), .rst_n(rst_n), .tick(tick), .regs(regs), .fm_in(fm_ch6),
    .valid_q(smp_valid), .left_q(ch6_left), .right_q(ch6_right)
  );
endmodule

// File: tb/test_dac6_ch6_sub.sv
module test_dac6_ch6_sub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_grp = 1'b0;
  logic [7:0]  wr_addr = 8'h00;
  logic [7:0]  wr_data = 8'h00;
  logic [13:0] fm_ch6 = 14'h0000;
  logic        smp_valid;
  logic [2:0]  slot_idx;
  logic [13:0] ch6_left, ch6_right;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int last_v = -1;
  int n_space = 0;
  logic [13:0] exp_l[$];
  logic [13:0] exp_r[$];
  string       exp_tag[$];

  always #2 clk = ~clk;

  dac6_ch6_sub i_dac6_ch6_sub (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(wr_grp),
    .wr_addr(wr_addr), .wr_data(wr_data), .fm_ch6(fm_ch6),
    .smp_valid(smp_valid), .slot_idx(slot_idx),
    .ch6_left(ch6_left), .ch6_right(ch6_right)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  function automatic logic [13:0] conv(input int s);
    return 14'((s - 128) * 64);
  endfunction

  task automatic reg_wr(input bit grp, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_grp = grp; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver side: push the expected pair, then wait for the monitor to consume it.
  task automatic expect_smp(input logic [13:0] l, input logic [13:0] r, input string tag);
    @(negedge clk);
    while (smp_valid) @(negedge clk);
    exp_l.push_back(l); exp_r.push_back(r); exp_tag.push_back(tag);
    while (exp_l.size() != 0) @(negedge clk);
  endtask

  // Monitor: compare each published sample with the queued expectation.
  always @(negedge clk) begin
    cyc++;
    if (rst_n && smp_valid) begin
      if (last_v >= 0 && n_space < 3) begin
        check((cyc - last_v) == 24, "R8 period", cyc - last_v, 24);
        n_space++;
      end
      last_v = cyc;
      if (exp_l.size() != 0) begin
        logic [13:0] el, er;
        string t;
        el = exp_l.pop_front(); er = exp_r.pop_front(); t = exp_tag.pop_front();
        check(ch6_left == el,  {t, " left"},  ch6_left,  el);
        check(ch6_right == er, {t, " right"}, ch6_right, er);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    fm_ch6 = 14'h0123;
    repeat (3) @(negedge clk);
    check(smp_valid == 1'b0 && ch6_left == 14'h0 && ch6_right == 14'h0, "R1 reset outputs",
          {smp_valid, ch6_left}, 0);
    rst_n = 1'b1;
    // R1: reset state gives FM pass-through on both sides
    expect_smp(14'h0123, 14'h0123, "R1 default passthrough");

    // R8: slot stepping
    @(negedge clk);
    while (!smp_valid) @(negedge clk);
    check(slot_idx == 3'd0, "R8 slot at pulse", slot_idx, 0);
    repeat (4) @(negedge clk);
    check(slot_idx == 3'd1, "R8 slot after 4", slot_idx, 1);
    repeat (19) @(negedge clk);
    check(slot_idx == 3'd5, "R8 last slot", slot_idx, 5);

    // R5: pass-through at extreme FM codes
    fm_ch6 = 14'h1FFF;
    expect_smp(14'h1FFF, 14'h1FFF, "R5 fm max");
    fm_ch6 = 14'h2000;
    expect_smp(14'h2000, 14'h2000, "R5 fm min");

    // R3: bit 7 clear with low bits set keeps the override off
    reg_wr(1'b0, 8'h2B, 8'h7F);
    reg_wr(1'b0, 8'h2A, 8'hFF);
    expect_smp(14'h2000, 14'h2000, "R3 low bits ignored");

    // R3/R4: enable, sample mode ignores FM
    reg_wr(1'b0, 8'h2B, 8'h81);
    expect_smp(conv(255), conv(255), "R4 sample 0xFF");
    reg_wr(1'b0, 8'h2A, 8'h00);
    expect_smp(conv(0), conv(0), "R4 sample 0x00");
    reg_wr(1'b0, 8'h2A, 8'h80);
    expect_smp(14'h0000, 14'h0000, "R4 sample 0x80");
    reg_wr(1'b0, 8'h2A, 8'h81);
    expect_smp(14'h0040, 14'h0040, "R4 sample 0x81");

    // R2: last write in a period wins
    reg_wr(1'b0, 8'h2A, 8'h10);
    reg_wr(1'b0, 8'h2A, 8'hC3);
    expect_smp(conv(8'hC3), conv(8'hC3), "R2 overwrite");

    // R7: wrong-group writes ignored
    reg_wr(1'b1, 8'h2A, 8'h05);
    reg_wr(1'b1, 8'h2B, 8'h00);
    reg_wr(1'b0, 8'hB6, 8'h00);
    expect_smp(conv(8'hC3), conv(8'hC3), "R7 wrong group");

    // R6: pan gates in sample mode
    reg_wr(1'b1, 8'hB6, 8'h80);
    expect_smp(conv(8'hC3), 14'h0, "R6 left only dac");
    reg_wr(1'b1, 8'hB6, 8'h40);
    expect_smp(14'h0, conv(8'hC3), "R6 right only dac");
    reg_wr(1'b1, 8'hB6, 8'h00);
    expect_smp(14'h0, 14'h0, "R6 both closed dac");

    // R3/R6: disable, pan gates in FM mode
    reg_wr(1'b0, 8'h2B, 8'h00);
    fm_ch6 = 14'h0ABC;
    reg_wr(1'b1, 8'hB6, 8'h80);
    expect_smp(14'h0ABC, 14'h0, "R6 left only fm");
    reg_wr(1'b1, 8'hB6, 8'h40);
    expect_smp(14'h0, 14'h0ABC, "R6 right only fm");
    reg_wr(1'b1, 8'hB6, 8'hC0);
    expect_smp(14'h0ABC, 14'h0ABC, "R6 both open fm");

    // R9: hold between pulses while inputs change
    @(negedge clk);
    while (!smp_valid) @(negedge clk);
    fm_ch6 = 14'h0555;
    reg_wr(1'b0, 8'h2B, 8'h80);
    repeat (8) @(negedge clk);
    check(ch6_left == 14'h0ABC && ch6_right == 14'h0ABC, "R9 hold", ch6_left, 14'h0ABC);

    repeat (30) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule